// File: doc/BRIEF.md
# DDR3 Power-Up Command Sequencer

This block brings a two-rank DDR3 memory out of power-up by driving the command port of a memory controller. A single `start_i` pulse begins the run. The block first requests power-up and waits for the controller to report that power-up is complete. It then issues a fixed series of commands. Each command is one 32-bit word, presented with a one-cycle strobe. The word carries a start flag that the controller clears when the command has finished. The controller reports that flag back on `cmd_busy_i`. The sequencer does not send the next word until it reads that flag back as low.

The mode-register contents are built inside the block from three timing inputs: CAS latency, CAS write latency and write recovery. These inputs are captured when the run starts. Every command selects both ranks.

The run ends in one of two ways. A one-cycle `done_o` pulse reports success. A sticky `timeout_o` flag reports that power-up never completed within the allowed number of cycles.

Top module: `ddr3_boot_seq`

## Requirements
- R1: After a synchronous reset, `cmd_valid_o`, `done_o`, `timeout_o` and `pwr_up_req_o` are all low, and a reset clears a previously set timeout.
- R2: Every command word has these fields:
  - bit 31 is the start flag and is set;
  - bits 21 and 20 select rank 1 and rank 0, and both are set;
  - bits 19:17 hold the mode-register number;
  - bits 16:4 hold the mode-register data;
  - bits 3:0 hold the command code: DESELECT=0, PRECHARGE-ALL=1, MRS=3, ZQCL=5.
- R3: A start pulse seen while idle raises `pwr_up_req_o` in the following cycle. The request stays high until `pwr_up_done_i` is sampled high. The first strobe appears in the cycle after that sample.
- R4: After each strobe the block waits one cycle and then polls `cmd_busy_i`. The next strobe appears in the cycle after the first clock edge that samples `cmd_busy_i` low, so strobes are never back to back.
- R5: When DESELECT completes, the block waits `CYC_PER_US` clock edges before it strobes PRECHARGE-ALL.
- R6: The commands are issued in this order: DESELECT, PRECHARGE-ALL, MRS to MR2, MRS to MR3, MRS to MR1, MRS to MR0, ZQCL.
- R7: `done_o` pulses for exactly one cycle, in the cycle after the edge that sees ZQCL complete. The block then returns to idle, and a new start pulse runs the whole series again.
- R8: If `pwr_up_done_i` is not sampled high on any of the `PWR_TMO_CYC` edges after the start, the block does the following until reset:
  - sets `timeout_o` and keeps it set;
  - drops the power-up request;
  - issues no command;
  - ignores start pulses.
- R9: MR0 fields:
  - bits 11:9 hold (tWR−4) when tWR≤8, and (tWR/2) mod 8 otherwise;
  - bit 8 (DLL reset) is 1;
  - bits 1:0 (burst length 8) are 0.
- R10: MR0 CAS-latency field: bits 6:4 hold (CL−4) mod 8, and bit 2 holds bit 3 of (CL−4).
- R11: An odd tWR above 8 is rounded up to the next even value before MR0 is encoded.
- R12: The other mode registers:
  - MR1 = 0x040 (only bit 6 set, 120 Ω termination);
  - MR2 holds (CWL−5) mod 8 in bits 5:3;
  - MR3 = 0.
- R13: A start pulse that arrives while a sequence is in progress has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin the power-up series (honoured only when idle) |
| cl_i | input | CL_W | CAS latency in clocks |
| cwl_i | input | CWL_W | CAS write latency in clocks |
| twr_i | input | TWR_W | Write recovery in clocks |
| pwr_up_req_o | output | 1 | Power-up request to the controller |
| pwr_up_done_i | input | 1 | Controller reports power-up complete |
| cmd_valid_o | output | 1 | One-cycle strobe writing `cmd_word_o` |
| cmd_word_o | output | 32 | Command word |
| cmd_busy_i | input | 1 | Read-back of the start flag; high while a command executes |
| done_o | output | 1 | One-cycle pulse when ZQCL completes |
| timeout_o | output | 1 | Sticky power-up timeout flag |

## Verification
The hardest case to reach is the power-up deadline itself. It has two sides: completion that arrives on the very last edge that is still honoured, and completion that arrives one edge later. Both must be placed exactly, counted from the edge that samples the start pulse.

The stimulus counts falling edges after the start pulse and raises `pwr_up_done_i` so that the first edge to see it is edge `PWR_TMO_CYC`. It then repeats the run with completion held off entirely, to drive the block into the timeout state. While the block is locked in that state, the stimulus applies start and power-done together, to show that the block stays silent.

The command port is played by a model whose busy time varies between runs. This moves the polling boundary across the strobe spacing.

// File: rtl/ddr3_boot_pkg.sv
package ddr3_boot_pkg;

  localparam int CMD_W      = 32;
  localparam int START_BIT  = 31;
  localparam int RANK1_BIT  = 21;
  localparam int RANK0_BIT  = 20;
  localparam int MRNUM_LSB  = 17;
  localparam int MRNUM_W    = 3;
  localparam int MRDATA_LSB = 4;
  localparam int MRDATA_W   = 13;
  localparam int OP_W       = 4;

  typedef enum logic [OP_W-1:0] {
    OP_DESEL = 4'd0,
    OP_PREA  = 4'd1,
    OP_REF   = 4'd2,
    OP_MRS   = 4'd3,
    OP_ZQCS  = 4'd4,
    OP_ZQCL  = 4'd5,
    OP_RSTL  = 4'd6,
    OP_MRR   = 4'd8,
    OP_DPDE  = 4'd9
  } dram_op_e;

  // Order of this enum is the issue order of the series.
  typedef enum logic [2:0] {
    ST_DESEL = 3'd0,
    ST_PREA  = 3'd1,
    ST_MR2   = 3'd2,
    ST_MR3   = 3'd3,
    ST_MR1   = 3'd4,
    ST_MR0   = 3'd5,
    ST_ZQCL  = 3'd6
  } boot_step_e;

  typedef enum logic [2:0] {
    SQ_IDLE  = 3'd0,
    SQ_PWRUP = 3'd1,
    SQ_HOLD  = 3'd2,
    SQ_POLL  = 3'd3,
    SQ_PAUSE = 3'd4,
    SQ_FAIL  = 3'd5
  } seq_state_e;

  function automatic logic [CMD_W-1:0] pack_cmd(
    input dram_op_e              op,
    input logic [MRNUM_W-1:0]    mr,
    input logic [MRDATA_W-1:0]   data
  );
    logic [CMD_W-1:0] w;
    w = '0;
    w[START_BIT] = 1'b1;
    w[RANK1_BIT] = 1'b1;
    w[RANK0_BIT] = 1'b1;
    w[MRNUM_LSB +: MRNUM_W]   = mr;
    w[MRDATA_LSB +: MRDATA_W] = data;
    w[OP_W-1:0] = op;
    return w;
  endfunction

endpackage

// File: rtl/ddr3_mode_enc.sv
module ddr3_mode_enc
  import ddr3_boot_pkg::*;
#(
  parameter int CL_W  = 4,
  parameter int CWL_W = 4,
  parameter int TWR_W = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load_i,
  input  logic [CL_W-1:0]     cl_i,
  input  logic [CWL_W-1:0]    cwl_i,
  input  logic [TWR_W-1:0]    twr_i,
  output logic [MRDATA_W-1:0] mr0_o,
  output logic [MRDATA_W-1:0] mr1_o,
  output logic [MRDATA_W-1:0] mr2_o,
  output logic [MRDATA_W-1:0] mr3_o
);

  localparam int TW_X = TWR_W + 1;

  logic [CL_W-1:0]     cl_off;
  logic [CWL_W-1:0]    cwl_off;
  logic [TW_X-1:0]     twr_ext;
  logic [TW_X-1:0]     twr_even;
  logic [2:0]          wr_code;
  logic [MRDATA_W-1:0] mr0_d;
  logic [MRDATA_W-1:0] mr1_d;
  logic [MRDATA_W-1:0] mr2_d;

  assign cl_off  = cl_i - CL_W'(4);
  assign cwl_off = cwl_i - CWL_W'(5);
  assign twr_ext = {1'b0, twr_i};

  // Round odd recovery values above 8 up to the next even value.
  always_comb begin
    twr_even = twr_ext;
    if (twr_ext > TW_X'(8)) begin
      twr_even = twr_ext + {{(TW_X-1){1'b0}}, twr_ext[0]};
    end
    if (twr_even <= TW_X'(8)) begin
      wr_code = 3'(twr_even - TW_X'(4));
    end else begin
      wr_code = twr_even[3:1];
    end
  end

  always_comb begin
    mr0_d       = '0;
    mr0_d[11:9] = wr_code;
    mr0_d[8]    = 1'b1;
    mr0_d[6:4]  = cl_off[2:0];
    mr0_d[2]    = cl_off[3];
    mr0_d[1:0]  = 2'b00;
    mr1_d       = '0;
    mr1_d[6]    = 1'b1;
    mr2_d       = '0;
    mr2_d[5:3]  = cwl_off[2:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mr0_o <= '0;
      mr1_o <= '0;
      mr2_o <= '0;
      mr3_o <= '0;
    end else if (load_i) begin
      mr0_o <= mr0_d;
      mr1_o <= mr1_d;
      mr2_o <= mr2_d;
      mr3_o <= '0;
    end
  end

endmodule

// File: rtl/ddr3_span_timer.sv
module ddr3_span_timer #(
  parameter int LIMIT = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  output logic expired_o
);

  localparam int CNT_W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      cnt_q <= '0;
    end else if (cnt_q != LAST) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  // True on the LIMIT-th edge since run_i was raised.
  assign expired_o = run_i && (cnt_q == LAST);

endmodule

// File: rtl/ddr3_boot_fsm.sv
module ddr3_boot_fsm
  import ddr3_boot_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  input  logic                pwr_done_i,
  input  logic                busy_i,
  input  logic                pwr_expired_i,
  input  logic                us_expired_i,
  input  logic [MRDATA_W-1:0] mr0_i,
  input  logic [MRDATA_W-1:0] mr1_i,
  input  logic [MRDATA_W-1:0] mr2_i,
  input  logic [MRDATA_W-1:0] mr3_i,
  output logic                cfg_load_o,
  output logic                pwr_run_o,
  output logic                us_run_o,
  output logic                pwr_req_o,
  output logic                cmd_valid_o,
  output logic [CMD_W-1:0]    cmd_word_o,
  output logic                done_o,
  output logic                timeout_o
);

  seq_state_e state_q;
  boot_step_e step_q;
  boot_step_e step_nx;

  function automatic logic [CMD_W-1:0] cmd_for(input boot_step_e s);
    case (s)
      ST_DESEL: return pack_cmd(OP_DESEL, 3'd0, '0);
      ST_PREA:  return pack_cmd(OP_PREA,  3'd0, '0);
      ST_MR2:   return pack_cmd(OP_MRS,   3'd2, mr2_i);
      ST_MR3:   return pack_cmd(OP_MRS,   3'd3, mr3_i);
      ST_MR1:   return pack_cmd(OP_MRS,   3'd1, mr1_i);
      ST_MR0:   return pack_cmd(OP_MRS,   3'd0, mr0_i);
      ST_ZQCL:  return pack_cmd(OP_ZQCL,  3'd0, '0);
      default:  return pack_cmd(OP_DESEL, 3'd0, '0);
    endcase
  endfunction

  assign step_nx    = boot_step_e'(step_q + 3'd1);
  assign cfg_load_o = (state_q == SQ_IDLE) && start_i;
  assign pwr_run_o  = (state_q == SQ_PWRUP);
  assign us_run_o   = (state_q == SQ_PAUSE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= SQ_IDLE;
      step_q      <= ST_DESEL;
      pwr_req_o   <= 1'b0;
      cmd_valid_o <= 1'b0;
      cmd_word_o  <= '0;
      done_o      <= 1'b0;
      timeout_o   <= 1'b0;
    end else begin
      cmd_valid_o <= 1'b0;
      done_o      <= 1'b0;
      case (state_q)
        SQ_IDLE: begin
          if (start_i) begin
            state_q   <= SQ_PWRUP;
            pwr_req_o <= 1'b1;
          end
        end
        SQ_PWRUP: begin
          if (pwr_done_i) begin
            pwr_req_o   <= 1'b0;
            step_q      <= ST_DESEL;
            cmd_valid_o <= 1'b1;
            cmd_word_o  <= cmd_for(ST_DESEL);
            state_q     <= SQ_HOLD;
          end else if (pwr_expired_i) begin
            pwr_req_o <= 1'b0;
            timeout_o <= 1'b1;
            state_q   <= SQ_FAIL;
          end
        end
        SQ_HOLD: begin
          // Give the port one cycle to raise its busy flag.
          state_q <= SQ_POLL;
        end
        SQ_POLL: begin
          if (!busy_i) begin
            if (step_q == ST_DESEL) begin
              state_q <= SQ_PAUSE;
            end else if (step_q == ST_ZQCL) begin
              done_o  <= 1'b1;
              state_q <= SQ_IDLE;
            end else begin
              step_q      <= step_nx;
              cmd_valid_o <= 1'b1;
              cmd_word_o  <= cmd_for(step_nx);
              state_q     <= SQ_HOLD;
            end
          end
        end
        SQ_PAUSE: begin
          if (us_expired_i) begin
            step_q      <= ST_PREA;
            cmd_valid_o <= 1'b1;
            cmd_word_o  <= cmd_for(ST_PREA);
            state_q     <= SQ_HOLD;
          end
        end
        SQ_FAIL: begin
          state_q <= SQ_FAIL;
        end
        default: begin
          state_q <= SQ_IDLE;
        end
      endcase
    end
  end

endmodule

// File: rtl/ddr3_boot_seq.sv
module ddr3_boot_seq
  import ddr3_boot_pkg::*;
#(
  parameter int CL_W        = 4,
  parameter int CWL_W       = 4,
  parameter int TWR_W       = 5,
  parameter int CYC_PER_US  = 100,
  parameter int PWR_TMO_CYC = 50_000_000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [CL_W-1:0]  cl_i,
  input  logic [CWL_W-1:0] cwl_i,
  input  logic [TWR_W-1:0] twr_i,
  output logic             pwr_up_req_o,
  input  logic             pwr_up_done_i,
  output logic             cmd_valid_o,
  output logic [31:0]      cmd_word_o,
  input  logic             cmd_busy_i,
  output logic             done_o,
  output logic             timeout_o
);

  logic                cfg_load;
  logic                pwr_run;
  logic                us_run;
  logic                pwr_expired;
  logic                us_expired;
  logic [MRDATA_W-1:0] mr0;
  logic [MRDATA_W-1:0] mr1;
  logic [MRDATA_W-1:0] mr2;
  logic [MRDATA_W-1:0] mr3;

  ddr3_mode_enc #(
    .CL_W  (CL_W),
    .CWL_W (CWL_W),
    .TWR_W (TWR_W)
  ) u_enc (
    .clk    (clk),
    .rst    (rst),
    .load_i (cfg_load),
    .cl_i   (cl_i),
    .cwl_i  (cwl_i),
    .twr_i  (twr_i),
    .mr0_o  (mr0),
    .mr1_o  (mr1),
    .mr2_o  (mr2),
    .mr3_o  (mr3)
  );

  ddr3_span_timer #(.LIMIT(PWR_TMO_CYC)) u_pwr_tmr (
    .clk       (clk),
    .rst       (rst),
    .run_i     (pwr_run),
    .expired_o (pwr_expired)
  );

  ddr3_span_timer #(.LIMIT(CYC_PER_US)) u_us_tmr (
    .clk       (clk),
    .rst       (rst),
    .run_i     (us_run),
    .expired_o (us_expired)
  );

  ddr3_boot_fsm u_fsm (
    .clk           (clk),
    .rst           (rst),
    .start_i       (start_i),
    .pwr_done_i    (pwr_up_done_i),
    .busy_i        (cmd_busy_i),
    .pwr_expired_i (pwr_expired),
    .us_expired_i  (us_expired),
    .mr0_i         (mr0),
    .mr1_i         (mr1),
    .mr2_i         (mr2),
    .mr3_i         (mr3),
    .cfg_load_o    (cfg_load),
    .pwr_run_o     (pwr_run),
    .us_run_o      (us_run),
    .pwr_req_o     (pwr_up_req_o),
    .cmd_valid_o   (cmd_valid_o),
    .cmd_word_o    (cmd_word_o),
    .done_o        (done_o),
    .timeout_o     (timeout_o)
  );

endmodule

// File: rtl/ddr3_boot_seq_chk.sv
module ddr3_boot_seq_chk (
  input logic        clk,
  input logic        rst,
  input logic        pwr_up_req_o,
  input logic        pwr_up_done_i,
  input logic        cmd_valid_o,
  input logic [31:0] cmd_word_o,
  input logic        cmd_busy_i,
  input logic        done_o,
  input logic        timeout_o
);

  p_rst_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!cmd_valid_o && !done_o && !timeout_o && !pwr_up_req_o));

  p_word_fmt_r2: assert property (@(posedge clk) disable iff (rst)
    cmd_valid_o |-> (cmd_word_o[31] && (cmd_word_o[21:20] == 2'b11)));

  p_req_release_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(pwr_up_req_o) |-> ($past(pwr_up_done_i) || timeout_o));

  p_busy_blocks_r4: assert property (@(posedge clk) disable iff (rst)
    cmd_busy_i |=> !cmd_valid_o);

  p_strobe_gap_r4: assert property (@(posedge clk) disable iff (rst)
    cmd_valid_o |=> !cmd_valid_o);

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  p_tmo_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    timeout_o |=> timeout_o);

  p_tmo_silent_r8: assert property (@(posedge clk) disable iff (rst)
    timeout_o |-> (!cmd_valid_o && !pwr_up_req_o && !done_o));

endmodule

bind ddr3_boot_seq ddr3_boot_seq_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .pwr_up_req_o  (pwr_up_req_o),
  .pwr_up_done_i (pwr_up_done_i),
  .cmd_valid_o   (cmd_valid_o),
  .cmd_word_o    (cmd_word_o),
  .cmd_busy_i    (cmd_busy_i),
  .done_o        (done_o),
  .timeout_o     (timeout_o)
);

// File: tb/ddr3_boot_seq_tb.sv
module ddr3_boot_seq_tb;

  localparam int US  = 50;
  localparam int TMO = 200;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst   = 1'b1;
  logic        start = 1'b0;
  logic        pdone = 1'b0;
  logic [3:0]  cl    = 4'd6;
  logic [3:0]  cwl   = 4'd5;
  logic [4:0]  twr   = 5'd6;
  logic        req, cv, dn, to, busy;
  logic [31:0] cw;

  int lat      = 3;
  int busy_cnt = 0;
  int cyc      = 0;
  logic [31:0] seen_q[$];
  int          seen_t[$];
  int  n_chk = 0;
  int  n_fail = 0;
  bit  model_on = 1'b0;

  ddr3_boot_seq #(
    .CYC_PER_US  (US),
    .PWR_TMO_CYC (TMO)
  ) u_dut (
    .clk           (clk),
    .rst           (rst),
    .start_i       (start),
    .cl_i          (cl),
    .cwl_i         (cwl),
    .twr_i         (twr),
    .pwr_up_req_o  (req),
    .pwr_up_done_i (pdone),
    .cmd_valid_o   (cv),
    .cmd_word_o    (cw),
    .cmd_busy_i    (busy),
    .done_o        (dn),
    .timeout_o     (to)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Command port model: start flag reads back high for lat cycles.
  assign busy = (busy_cnt > 0);
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) begin
      busy_cnt <= 0;
    end else if (cv) begin
      busy_cnt <= lat;
      seen_q.push_back(cw);
      seen_t.push_back(cyc);
    end else if (busy_cnt > 0) begin
      busy_cnt <= busy_cnt - 1;
    end
  end

  // Expected encodings from the requirements.
  function automatic int f_wr(input int t);
    int w;
    w = t;
    if (w > 8 && (w % 2) == 1) w = w + 1;
    if (w <= 8) return w - 4;
    return (w / 2) % 8;
  endfunction

  function automatic int f_mr0(input int c, input int t);
    return f_wr(t) * 512 + 256 + ((c - 4) % 8) * 16 + (((c - 4) / 8) % 2) * 4;
  endfunction

  function automatic logic [31:0] f_cmd(input int code, input int mr, input int data);
    return 32'h8030_0000 + 32'(mr * 131072) + 32'(data * 16) + 32'(code);
  endfunction

  // Reference model, evaluated on every clock.
  int          m_ph  = 0;
  int          m_cnt = 0;
  logic        e_v = 1'b0, e_d = 1'b0, e_t = 1'b0, e_r = 1'b0;
  logic [31:0] e_w = '0;
  logic [31:0] plan_q[$];

  always @(posedge clk) begin
    if (rst) begin
      m_ph <= 0;
      e_v  <= 1'b0;
      e_d  <= 1'b0;
      e_t  <= 1'b0;
      e_r  <= 1'b0;
      e_w  <= '0;
      plan_q.delete();
    end else begin
      e_v <= 1'b0;
      e_d <= 1'b0;
      case (m_ph)
        0: if (start) begin
          m_ph  <= 1;
          m_cnt <= 1;
          e_r   <= 1'b1;
          plan_q.delete();
          plan_q.push_back(f_cmd(0, 0, 0));
          plan_q.push_back(f_cmd(1, 0, 0));
          plan_q.push_back(f_cmd(3, 2, ((int'(cwl) - 5) % 8) * 8));
          plan_q.push_back(f_cmd(3, 3, 0));
          plan_q.push_back(f_cmd(3, 1, 64));
          plan_q.push_back(f_cmd(3, 0, f_mr0(int'(cl), int'(twr))));
          plan_q.push_back(f_cmd(5, 0, 0));
        end
        1: if (pdone) begin
          e_r  <= 1'b0;
          e_v  <= 1'b1;
          e_w  <= plan_q.pop_front();
          m_ph <= 2;
        end else if (m_cnt == TMO) begin
          e_r  <= 1'b0;
          e_t  <= 1'b1;
          m_ph <= 9;
        end else begin
          m_cnt <= m_cnt + 1;
        end
        2: m_ph <= 3;
        3: if (!busy) begin
          if (e_w[3:0] == 4'd0) begin
            m_ph  <= 4;
            m_cnt <= 1;
          end else if (plan_q.size() == 0) begin
            e_d  <= 1'b1;
            m_ph <= 0;
          end else begin
            e_v  <= 1'b1;
            e_w  <= plan_q.pop_front();
            m_ph <= 2;
          end
        end
        4: if (m_cnt == US) begin
          e_v  <= 1'b1;
          e_w  <= plan_q.pop_front();
          m_ph <= 2;
        end else begin
          m_cnt <= m_cnt + 1;
        end
        default: m_ph <= m_ph;
      endcase
    end
  end

  always @(negedge clk) begin
    if (model_on) begin
      check(cv === e_v, "R4 strobe timing", 32'(cv), 32'(e_v));
      if (e_v) check(cw === e_w, "R6 command word", cw, e_w);
      check(dn === e_d, "R7 done pulse", 32'(dn), 32'(e_d));
      check(to === e_t, "R8 timeout flag", 32'(to), 32'(e_t));
      check(req === e_r, "R3 power-up request", 32'(req), 32'(e_r));
    end
  end

  task automatic run_seq(input int c, input int w, input int t,
                         input int l, input int d, input bit poke);
    int guard;
    cl  = 4'(c);
    cwl = 4'(w);
    twr = 5'(t);
    lat = l;
    seen_q.delete();
    seen_t.delete();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (d) @(negedge clk);
    pdone = 1'b1;
    if (poke) begin
      repeat (20) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    guard = 0;
    while (!dn && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    check(dn === 1'b1, "R7 done seen", 32'(dn), 32'd1);
    @(negedge clk);
    pdone = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(cv === 1'b0,  "R1 reset strobe",  32'(cv),  32'd0);
    check(dn === 1'b0,  "R1 reset done",    32'(dn),  32'd0);
    check(to === 1'b0,  "R1 reset timeout", 32'(to),  32'd0);
    check(req === 1'b0, "R1 reset request", 32'(req), 32'd0);
    rst = 1'b0;
    model_on = 1'b1;
    repeat (2) @(negedge clk);

    // Run A: CL6 CWL5 tWR6, busy 3, late start pulse mid-run.
    run_seq(6, 5, 6, 3, 4, 1'b1);
    check(seen_q.size() == 7, "R13 command count", 32'(seen_q.size()), 32'd7);
    if (seen_q.size() == 7) begin
      check(seen_q[0] == 32'h8030_0000, "R6 DESELECT first", seen_q[0], 32'h8030_0000);
      check(seen_q[1] == 32'h8030_0001, "R2 PRECHARGE-ALL",  seen_q[1], 32'h8030_0001);
      check(seen_q[2] == 32'h8034_0003, "R12 MR2 word",      seen_q[2], 32'h8034_0003);
      check(seen_q[3] == 32'h8036_0003, "R12 MR3 word",      seen_q[3], 32'h8036_0003);
      check(seen_q[4] == 32'h8032_0403, "R12 MR1 word",      seen_q[4], 32'h8032_0403);
      check(seen_q[5] == 32'h8030_5203, "R9 MR0 word",       seen_q[5], 32'h8030_5203);
      check(seen_q[6] == 32'h8030_0005, "R6 ZQCL last",      seen_q[6], 32'h8030_0005);
      check(seen_t[1] - seen_t[0] == 2 + 3 + US, "R5 pause after DESELECT",
            32'(seen_t[1] - seen_t[0]), 32'(2 + 3 + US));
      check(seen_t[2] - seen_t[1] == 2 + 3, "R4 strobe spacing",
            32'(seen_t[2] - seen_t[1]), 32'd5);
    end

    // Run B: CL11 CWL8 tWR11 (odd, rounds to 12), busy 1.
    run_seq(11, 8, 11, 1, 0, 1'b0);
    if (seen_q.size() == 7) begin
      check(seen_q[5] == 32'h8030_D703, "R11 MR0 rounded tWR", seen_q[5], 32'h8030_D703);
      check(seen_q[2] == 32'h8034_0183, "R12 MR2 CWL8",        seen_q[2], 32'h8034_0183);
      check(seen_t[2] - seen_t[1] == 3, "R4 strobe spacing busy1",
            32'(seen_t[2] - seen_t[1]), 32'd3);
    end else begin
      check(1'b0, "R6 run B count", 32'(seen_q.size()), 32'd7);
    end

    // Run C: CL12 tWR16 CWL9, power done on the last honoured edge.
    run_seq(12, 9, 16, 5, TMO - 1, 1'b0);
    check(to === 1'b0, "R8 boundary no timeout", 32'(to), 32'd0);
    if (seen_q.size() == 7) begin
      check(seen_q[5] == 32'h8030_1043, "R10 MR0 CL bit3", seen_q[5], 32'h8030_1043);
      check(seen_q[2] == 32'h8034_0203, "R12 MR2 CWL9",    seen_q[2], 32'h8034_0203);
    end else begin
      check(1'b0, "R3 run C count", 32'(seen_q.size()), 32'd7);
    end

    // Run D: CL5 tWR9 (rounds to 10).
    run_seq(5, 6, 9, 2, 1, 1'b0);
    if (seen_q.size() == 7)
      check(seen_q[5] == 32'h8030_B103, "R11 MR0 tWR9", seen_q[5], 32'h8030_B103);

    // Run E: CL7 tWR8 (boundary of the linear rule).
    run_seq(7, 6, 8, 2, 2, 1'b0);
    if (seen_q.size() == 7)
      check(seen_q[5] == 32'h8030_9303, "R9 MR0 tWR8", seen_q[5], 32'h8030_9303);

    // Timeout: power-up never completes.
    seen_q.delete();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (TMO + 5) @(negedge clk);
    check(to === 1'b1,  "R8 timeout set",      32'(to),  32'd1);
    check(req === 1'b0, "R8 request dropped",  32'(req), 32'd0);
    start = 1'b1;
    pdone = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (60) @(negedge clk);
    check(seen_q.size() == 0, "R8 silent after timeout", 32'(seen_q.size()), 32'd0);
    check(to === 1'b1, "R8 timeout sticky", 32'(to), 32'd1);
    pdone = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    check(to === 1'b0, "R1 reset clears timeout", 32'(to), 32'd0);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule